// File: doc/BRIEF.md
# Audio Codec TDM Link Framer

This block drives the serial time-division-multiplexed link that connects a host to external audio codecs. From a single internal clock running at twice the bit rate (48 MHz by default) it produces the codec reset, a 24 MHz bit clock, a frame sync that repeats every 500 bit periods (48 kHz), and a serial output lane. The output lane changes on every internal clock cycle, so two output bits are carried per bit period. Two serial input lanes are sampled once per bit period.

At every frame boundary the block takes one command word from the host. It shifts that word out, MSB first, at the start of the next frame. At the same boundary it returns the response field captured on each input lane during the frame that just ended, together with a per-lane valid strobe. The `link_run` input drives the codec reset. While `link_run` is high, the link first runs a warm-up interval with the bit clock toggling and no sync. Framing starts only after that interval. Responses from the first full frame are discarded.

Top module: `tdm_link_framer`

## Requirements
- R1: While `codec_rst_n` is high, `bclk` toggles on every clock cycle. Each bit period is one cycle with `bclk` high followed by one cycle with `bclk` low. While `codec_rst_n` is low, `bclk` stays low.
- R2: The first cycle in which `codec_rst_n` is high is the first cycle of the warm-up. The warm-up lasts WARM_BITS full bit periods with `sync` low and `sdo` low, and `sync` rises directly after it.
- R3: `sync` is high for SYNC_BITS whole bit periods at the end of every FRAME_BITS-long frame. The first sync pulse after warm-up also lasts SYNC_BITS periods, and the first frame (frame 0) begins right after it.
- R4: The last clock cycle of each sync pulse is the frame boundary. In that cycle `cmd_take` equals `cmd_valid`, and in no other cycle is it high. If `cmd_valid` is high, `cmd_word` is latched there.
- R5: In the frame that follows, slot s (the s-th clock cycle after the frame starts, s = 0..CMD_W-1) carries bit CMD_W-1-s of the latched word on `sdo`.
- R6: All other output slots are zero. This includes every slot of a frame whose boundary had `cmd_valid` low, and all cycles of warm-up and sync.
- R7: Each input lane is sampled once per bit period, on the clock edge that ends the cycle in which `bclk` is low. Bits 0..RSP_W-1 of a frame form the lane's field. Bit 0 ends up in the field's MSB, and lane l occupies `rsp_data[l*RSP_W +: RSP_W]`.
- R8: At a frame boundary, `rsp_data` is loaded with each lane's field. `rsp_valid[l]` is high for exactly the first cycle of the next frame, and only if that lane's field MSB (the leading bit) is 1.
- R9: Input captured during frame 0 (and during warm-up and sync) never raises `rsp_valid` and does not change `rsp_data`. The first strobe can come at the end of frame 1.
- R10: One clock edge after `link_run` is sampled low, `codec_rst_n`, `bclk`, `sync`, `sdo` and `rsp_valid` are all low. Raising `link_run` again repeats the full warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low block reset |
| link_run | input | 1 | High to release the codecs and run the link |
| cmd_word | input | CMD_W | Command word for the next frame |
| cmd_valid | input | 1 | A command word is pending |
| cmd_take | output | 1 | Command consumed in this cycle (frame boundary) |
| codec_rst_n | output | 1 | Active-low reset to the codecs |
| bclk | output | 1 | Bit clock to the codecs |
| sync | output | 1 | Frame sync |
| sdo | output | 1 | Serial output lane, two slots per bit period |
| sdi | input | LANES | Serial input lanes |
| rsp_data | output | LANES*RSP_W | Captured response field per lane |
| rsp_valid | output | LANES | Per-lane response strobe |

## Verification
The bench builds the block with FRAME_BITS=48, SYNC_BITS=4 and WARM_BITS=6, keeping CMD_W=32, RSP_W=36 and two lanes. With these values a frame is only 96 cycles, so seven frames per session, run twice across a restart, can each be compared cycle by cycle against an arithmetic model of `bclk`, `sync`, `sdo`, `cmd_take`, `rsp_valid` and `rsp_data`. The command and response patterns cycle through pending and absent commands, leading bits of 0 and 1, frame-0 data that must be dropped, and input bits after the response field that must be ignored.

// File: rtl/tdm_link_framer.sv
module tdm_link_framer #(
  parameter int FRAME_BITS = 500,
  parameter int SYNC_BITS  = 4,
  parameter int WARM_BITS  = 100,
  parameter int CMD_W      = 32,
  parameter int RSP_W      = 36,
  parameter int LANES      = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   link_run,
  input  logic [CMD_W-1:0]       cmd_word,
  input  logic                   cmd_valid,
  output logic                   cmd_take,
  output logic                   codec_rst_n,
  output logic                   bclk,
  output logic                   sync,
  output logic                   sdo,
  input  logic [LANES-1:0]       sdi,
  output logic [LANES*RSP_W-1:0] rsp_data,
  output logic [LANES-1:0]       rsp_valid
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam int WW = $clog2(WARM_BITS + 1);
  localparam logic [BW-1:0] LAST_BIT   = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] SYNC_START = BW'(FRAME_BITS - SYNC_BITS);
  localparam logic [BW-1:0] RSP_END    = BW'(RSP_W);
  localparam logic [WW-1:0] WARM_LAST  = WW'(WARM_BITS - 1);

  typedef enum logic [1:0] {S_IDLE, S_WARM, S_FRAME} state_t;

  state_t           st;
  logic             ph;
  logic [BW-1:0]    bit_cnt;
  logic [WW-1:0]    warm_cnt;
  logic [1:0]       frames;
  logic [CMD_W-1:0] cmd_sh;
  logic [RSP_W-1:0] rsp_sh [LANES];
  logic             wrap;

  assign wrap        = (st == S_FRAME) && ph && (bit_cnt == LAST_BIT);
  assign codec_rst_n = (st != S_IDLE);
  assign bclk        = (st != S_IDLE) && !ph;
  assign sync        = (st == S_FRAME) && (bit_cnt >= SYNC_START);
  assign sdo         = cmd_sh[CMD_W-1];
  assign cmd_take    = wrap && cmd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ph        <= 1'b0;
      bit_cnt   <= '0;
      warm_cnt  <= '0;
      frames    <= '0;
      cmd_sh    <= '0;
      rsp_data  <= '0;
      rsp_valid <= '0;
      for (int l = 0; l < LANES; l++) rsp_sh[l] <= '0;
    end else if (!link_run) begin
      st        <= S_IDLE;
      ph        <= 1'b0;
      bit_cnt   <= '0;
      warm_cnt  <= '0;
      frames    <= '0;
      cmd_sh    <= '0;
      rsp_data  <= '0;
      rsp_valid <= '0;
      for (int l = 0; l < LANES; l++) rsp_sh[l] <= '0;
    end else begin
      rsp_valid <= '0;
      case (st)
        S_IDLE: begin
          st       <= S_WARM;
          ph       <= 1'b0;
          warm_cnt <= '0;
        end
        S_WARM: begin
          ph <= !ph;
          if (ph) begin
            if (warm_cnt == WARM_LAST) begin
              st      <= S_FRAME;
              bit_cnt <= SYNC_START;
            end else begin
              warm_cnt <= warm_cnt + 1'b1;
            end
          end
        end
        default: begin
          ph <= !ph;
          if (wrap) cmd_sh <= cmd_valid ? cmd_word : '0;
          else      cmd_sh <= {cmd_sh[CMD_W-2:0], 1'b0};
          if (ph) bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
          if (wrap && frames != 2'd2) frames <= frames + 1'b1;
          for (int l = 0; l < LANES; l++) begin
            if (ph && bit_cnt < RSP_END)
              rsp_sh[l] <= {rsp_sh[l][RSP_W-2:0], sdi[l]};
            if (wrap && frames == 2'd2) begin
              rsp_data[l*RSP_W +: RSP_W] <= rsp_sh[l];
              rsp_valid[l]               <= rsp_sh[l][RSP_W-1];
            end
          end
        end
      endcase
    end
  end
endmodule

module tdm_link_framer_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             codec_rst_n,
  input logic             bclk,
  input logic             sync,
  input logic             sdo,
  input logic             cmd_take,
  input logic [LANES-1:0] rsp_valid
);
  p_bclk_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (codec_rst_n && $past(codec_rst_n)) |-> (bclk != $past(bclk)));

  p_sync_on_bit_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (codec_rst_n && $past(codec_rst_n) && sync != $past(sync)) |-> bclk);

  p_take_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |-> (sync && !bclk));

  p_sdo_zero_in_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> !sdo);

  p_valid_after_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |-> (bclk && !sync && $past(sync)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !codec_rst_n |-> (!bclk && !sync && !sdo && rsp_valid == '0));
endmodule

bind tdm_link_framer tdm_link_framer_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .codec_rst_n(codec_rst_n), .bclk(bclk),
  .sync(sync), .sdo(sdo), .cmd_take(cmd_take), .rsp_valid(rsp_valid)
);

// File: tb/tdm_link_framer_bench.sv
module tdm_link_framer_bench;
  localparam int FB = 48;
  localparam int SB = 4;
  localparam int WB = 6;
  localparam int CW = 32;
  localparam int RW = 36;
  localparam int NL = 2;
  localparam int NF = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             link_run = 1'b0;
  logic [CW-1:0]    cmd_word = '0;
  logic             cmd_valid = 1'b0;
  logic             cmd_take;
  logic             codec_rst_n, bclk, sync, sdo;
  logic [NL-1:0]    sdi = '0;
  logic [NL*RW-1:0] rsp_data;
  logic [NL-1:0]    rsp_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  tdm_link_framer #(.FRAME_BITS(FB), .SYNC_BITS(SB), .WARM_BITS(WB),
                    .CMD_W(CW), .RSP_W(RW), .LANES(NL)) u_tdm_link_framer (
    .clk(clk), .rst_n(rst_n), .link_run(link_run), .cmd_word(cmd_word),
    .cmd_valid(cmd_valid), .cmd_take(cmd_take), .codec_rst_n(codec_rst_n),
    .bclk(bclk), .sync(sync), .sdo(sdo), .sdi(sdi), .rsp_data(rsp_data),
    .rsp_valid(rsp_valid));

  task automatic chk(input bit ok, input string tag, input int n,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, n, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] cmd_of(input int f, input int seed);
    return CW'(32'h8000_0001 ^ (f * 32'h1357_9BDF) ^ seed);
  endfunction

  function automatic bit has_cmd(input int f);
    return (f % 3) != 1;
  endfunction

  function automatic bit lead_of(input int f, input int l);
    return (f == 0) ? 1'b1 : (((f + l) % 3) != 0);
  endfunction

  function automatic logic [RW-1:0] rsp_of(input int f, input int l, input int seed);
    logic [63:0] h;
    h = 64'(f) * 64'h9E37_79B1 + 64'(l) * 64'h51 + 64'(seed);
    return {lead_of(f, l), h[RW-2:0]};
  endfunction

  // frame index of cycle n; -1 during warm-up and the first sync
  function automatic int frame_of(input int n);
    if (n < 2*WB + 2*SB) return -1;
    return (n - 2*WB - 2*SB) / (2*FB);
  endfunction

  task automatic run_session(input int seed);
    int total;
    total = 2*WB + 2*SB + 2*FB*NF;
    @(negedge clk);
    link_run = 1'b1;
    for (int n = 0; n < total; n++) begin
      int fn, f, q, m;
      logic eb, es, ed, et;
      logic [NL-1:0] ev;
      @(negedge clk);
      // drive inputs seen by the edge that closes cycle n
      fn = frame_of(n + 1);
      if (fn < 0) begin
        cmd_valid = 1'b1;
        cmd_word  = '1;
      end else begin
        cmd_valid = has_cmd(fn);
        cmd_word  = cmd_of(fn, seed);
      end
      f = frame_of(n);
      if (f < 0) sdi = '1;
      else begin
        q = (n - 2*WB - 2*SB) % (2*FB);
        for (int l = 0; l < NL; l++) begin
          logic [RW-1:0] r;
          r = rsp_of(f, l, seed);
          sdi[l] = (q/2 < RW) ? r[RW-1-q/2] : 1'b1;
        end
      end
      #1;
      // expected outputs for cycle n
      ev = '0;
      et = 1'b0;
      if (n < 2*WB) begin
        eb = (n % 2) == 0; es = 1'b0; ed = 1'b0;
      end else if (n < 2*WB + 2*SB) begin
        m = n - 2*WB;
        eb = (m % 2) == 0; es = 1'b1; ed = 1'b0;
        et = (m == 2*SB - 1) && has_cmd(0);
      end else begin
        q = (n - 2*WB - 2*SB) % (2*FB);
        eb = (q % 2) == 0;
        es = (q / 2) >= FB - SB;
        if (q < CW && has_cmd(f)) begin
          logic [CW-1:0] c;
          c = cmd_of(f, seed);
          ed = c[CW-1-q];
        end else ed = 1'b0;
        et = (q == 2*FB - 1) && has_cmd(f + 1);
        if (q == 0 && f >= 2)
          for (int l = 0; l < NL; l++) ev[l] = lead_of(f - 1, l);
        if (f >= 2)
          for (int l = 0; l < NL; l++)
            chk(rsp_data[l*RW +: RW] == rsp_of(f - 1, l, seed), "R7", n,
                64'(rsp_data[l*RW +: RW]), 64'(rsp_of(f - 1, l, seed)));
      end
      chk(codec_rst_n == 1'b1, "R2", n, 64'(codec_rst_n), 64'd1);
      chk(bclk == eb, "R1", n, 64'(bclk), 64'(eb));
      chk(sync == es, (n < 2*WB) ? "R2" : "R3", n, 64'(sync), 64'(es));
      chk(sdo == ed, (ed || (f >= 0 && q < CW)) ? "R5" : "R6", n, 64'(sdo), 64'(ed));
      chk(cmd_take == et, "R4", n, 64'(cmd_take), 64'(et));
      chk(rsp_valid == ev, (f == 1 && q == 0) ? "R9" : "R8", n,
          64'(rsp_valid), 64'(ev));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(codec_rst_n == 0 && bclk == 0 && sync == 0 && sdo == 0 && rsp_valid == 0,
        "R10", -1, {59'd0, codec_rst_n, bclk, sync, sdo, |rsp_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(codec_rst_n == 0 && bclk == 0, "R10", -1, {62'd0, codec_rst_n, bclk}, 64'd0);
    run_session(32'h0000_0000);
    link_run = 1'b0;
    @(negedge clk);
    chk(codec_rst_n == 0 && bclk == 0 && sync == 0 && sdo == 0 && rsp_valid == 0,
        "R10", -1, {59'd0, codec_rst_n, bclk, sync, sdo, |rsp_valid}, 64'd0);
    repeat (3) @(negedge clk);
    chk(codec_rst_n == 0 && bclk == 0, "R10", -1, {62'd0, codec_rst_n, bclk}, 64'd0);
    run_session(32'h5A5A_0F0F);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule